// File: doc/BRIEF.md
# Trace Capture Cycle Filter

The filter sits between a processor bus monitor and a trace buffer. Each clock it looks at the bus cycle on its inputs: the cycle kind, the address and data, whether the fetch starts a change of flow, and whether the instruction is a background-entry opcode. It then decides whether that cycle becomes a trace record. The capture mode sets the rule. Normal mode keeps change-of-flow fetches. Loop mode keeps them too, but drops a fetch that repeats the address stored just before it. Detail mode keeps every data read and write together with its data. Profile mode stores nothing.

Records are only produced while the trigger logic holds the capture window open. A registered strobe marks each record for one clock. In profile mode the block keeps a sampled copy of the current instruction address. An external probe can poll it, and the copy does not change while a poll read is under way.

Top module: `trace_cycle_filter`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, store_o is 0, prof_addr_o is 0 and rec_addr_o is 0.
- R2: In mode_i=0 (normal), a valid fetch cycle (cyc_type_i=0) with cof_i=1 and win_i=1 gives store_o=1 in the next cycle, with rec_addr_o equal to its address, rec_has_data_o=0 and rec_data_o=0.
- R3: In normal mode, the following produce no record: fetches with cof_i=0, free cycles (type 1), data reads (type 2) and data writes (type 3).
- R4: A change-of-flow fetch with bgnd_i=1 is never stored, in either normal mode or loop mode (mode_i=1).
- R5: In loop mode, a change-of-flow fetch is stored unless its address equals the last address stored in loop mode. The sequence A,A,B,A stores A, B, A.
- R6: arm_i=1 forgets the last loop-mode address. A duplicate fetch that arrives in the same cycle as arm_i is stored.
- R7: In mode_i=2 (detail), reads and writes are stored with rec_has_data_o=1 and rec_data_o equal to the bus data. Fetch and free cycles are not stored, whatever cof_i is.
- R8: In mode_i=3 (profile), no cycle is stored.
- R9: With win_i=0, no cycle is stored, and the loop-mode last address is left unchanged.
- R10: In profile mode, insn_start_i=1 with poll_i=0 loads addr_i into prof_addr_o, which shows the new value in the next cycle.
- R11: While poll_i=1, prof_addr_o holds its value even if insn_start_i=1.
- R12: store_o is high for exactly one clock per qualifying cycle. Back-to-back qualifying cycles give back-to-back strobes, each with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Capture mode: 0 normal, 1 loop, 2 detail, 3 profile |
| cyc_valid_i | input | 1 | A bus cycle is present this clock |
| cyc_type_i | input | 2 | 0 fetch, 1 free, 2 read, 3 write |
| cof_i | input | 1 | Fetch begins a change of flow |
| bgnd_i | input | 1 | Instruction is a background-entry opcode |
| addr_i | input | AW | Bus / fetch address |
| data_i | input | DW | Bus data |
| arm_i | input | 1 | Capture armed; clears the loop history |
| win_i | input | 1 | Capture window from trigger logic |
| insn_start_i | input | 1 | Instruction start, for profile sampling |
| poll_i | input | 1 | External poll read in progress |
| store_o | output | 1 | Record strobe, one clock per record |
| rec_addr_o | output | AW | Record address |
| rec_data_o | output | DW | Record data (0 for fetch records) |
| rec_has_data_o | output | 1 | Record carries data |
| prof_addr_o | output | AW | Sampled instruction address for polling |

## Verification
Two events can meet in one clock: arming the capture, which clears the loop history, and a loop-mode fetch that repeats the address held in that history. The bench stores address A and then drives a second fetch of A together with arm_i. Clearing must win, so a strobe carrying A is expected. A second collision pairs a poll read with an instruction start. There the expected result is an unchanged profile address.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_LOOP    = 2'd1,
    MODE_DETAIL  = 2'd2,
    MODE_PROFILE = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_FREE  = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/trc_classify.sv
module trc_classify
  import trc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       valid_i,
  input  logic [1:0] kind_i,
  input  logic       cof_i,
  input  logic       bgnd_i,
  input  logic       win_i,
  output logic       norm_take_o,
  output logic       loop_cand_o,
  output logic       data_take_o
);
  cap_mode_e mode;
  cyc_kind_e kind;
  logic      live;
  logic      flow_fetch;

  assign mode = cap_mode_e'(mode_i);
  assign kind = cyc_kind_e'(kind_i);
  assign live = valid_i && win_i;
  // background entry never counts as change of flow
  assign flow_fetch = (kind == CYC_FETCH) && cof_i && !bgnd_i;

  always_comb begin
    norm_take_o = 1'b0;
    loop_cand_o = 1'b0;
    data_take_o = 1'b0;
    if (live) begin
      unique case (mode)
        MODE_NORMAL:  norm_take_o = flow_fetch;
        MODE_LOOP:    loop_cand_o = flow_fetch;
        MODE_DETAIL:  data_take_o = (kind == CYC_READ) || (kind == CYC_WRITE);
        default: ;
      endcase
    end
  end

  always_comb begin
    a_one_path_r12: assert ($countones({norm_take_o, loop_cand_o, data_take_o}) <= 1);
  end
endmodule

// File: rtl/trc_dup_track.sv
module trc_dup_track #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          cand_i,
  input  logic [AW-1:0] addr_i,
  output logic          pass_o
);
  logic [AW-1:0] last_q;
  logic          vld_q;
  logic          dup;

  // arm in the same cycle wins over the comparison
  assign dup    = vld_q && !arm_i && (last_q == addr_i);
  assign pass_o = cand_i && !dup;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      vld_q  <= 1'b0;
    end else if (pass_o) begin
      last_q <= addr_i;
      vld_q  <= 1'b1;
    end else if (arm_i) begin
      vld_q  <= 1'b0;
    end
  end

  p_hist_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> (vld_q && last_q == $past(addr_i)));
  p_hist_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cand_i && !arm_i) |=> ($stable(last_q) && $stable(vld_q)));
endmodule

// File: rtl/trc_prof_sample.sv
module trc_prof_sample #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          poll_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] prof_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         prof_addr_o <= '0;
    else if (en_i && start_i && !poll_i) prof_addr_o <= addr_i;
  end

  p_poll_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i |=> $stable(prof_addr_o));
  p_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && !poll_i) |=> (prof_addr_o == $past(addr_i)));
endmodule

// File: rtl/trc_record_reg.sv
module trc_record_reg #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          with_data_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          store_o,
  output logic [AW-1:0] rec_addr_o,
  output logic [DW-1:0] rec_data_o,
  output logic          rec_has_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o        <= 1'b0;
      rec_addr_o     <= '0;
      rec_data_o     <= '0;
      rec_has_data_o <= 1'b0;
    end else begin
      store_o <= take_i;
      if (take_i) begin
        rec_addr_o     <= addr_i;
        rec_data_o     <= with_data_i ? data_i : '0;
        rec_has_data_o <= with_data_i;
      end
    end
  end

  p_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !store_o);
endmodule

// File: rtl/trace_cycle_filter.sv
module trace_cycle_filter
  import trc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          cyc_valid_i,
  input  logic [1:0]    cyc_type_i,
  input  logic          cof_i,
  input  logic          bgnd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          arm_i,
  input  logic          win_i,
  input  logic          insn_start_i,
  input  logic          poll_i,
  output logic          store_o,
  output logic [AW-1:0] rec_addr_o,
  output logic [DW-1:0] rec_data_o,
  output logic          rec_has_data_o,
  output logic [AW-1:0] prof_addr_o
);
  logic norm_take, loop_cand, loop_pass, data_take, take;

  trc_classify u_class (
    .mode_i      (mode_i),
    .valid_i     (cyc_valid_i),
    .kind_i      (cyc_type_i),
    .cof_i       (cof_i),
    .bgnd_i      (bgnd_i),
    .win_i       (win_i),
    .norm_take_o (norm_take),
    .loop_cand_o (loop_cand),
    .data_take_o (data_take)
  );

  trc_dup_track #(.AW(AW)) u_dup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .cand_i (loop_cand),
    .addr_i (addr_i),
    .pass_o (loop_pass)
  );

  assign take = norm_take || loop_pass || data_take;

  trc_record_reg #(.AW(AW), .DW(DW)) u_rec (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .take_i         (take),
    .with_data_i    (data_take),
    .addr_i         (addr_i),
    .data_i         (data_i),
    .store_o        (store_o),
    .rec_addr_o     (rec_addr_o),
    .rec_data_o     (rec_data_o),
    .rec_has_data_o (rec_has_data_o)
  );

  trc_prof_sample #(.AW(AW)) u_prof (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (mode_i == MODE_PROFILE),
    .start_i     (insn_start_i),
    .poll_i      (poll_i),
    .addr_i      (addr_i),
    .prof_addr_o (prof_addr_o)
  );

  p_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> !store_o);
  p_profile_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PROFILE) |=> !store_o);
  p_bgnd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && bgnd_i && cyc_type_i == CYC_FETCH) |=> !store_o);
  p_detail_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DETAIL && (cyc_type_i == CYC_FETCH || cyc_type_i == CYC_FREE)) |=> !store_o);
  p_strobe_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> $past(cyc_valid_i && win_i));
endmodule

// File: tb/trace_cycle_filter_test.sv
module trace_cycle_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        valid = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic        cof = 1'b0;
  logic        bgnd = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        arm = 1'b0;
  logic        win = 1'b1;
  logic        start = 1'b0;
  logic        poll = 1'b0;
  logic        store;
  logic [15:0] rec_addr, rec_data, prof_addr;
  logic        rec_hd;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  trace_cycle_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cyc_valid_i(valid),
    .cyc_type_i(kind), .cof_i(cof), .bgnd_i(bgnd), .addr_i(addr),
    .data_i(data), .arm_i(arm), .win_i(win), .insn_start_i(start),
    .poll_i(poll), .store_o(store), .rec_addr_o(rec_addr),
    .rec_data_o(rec_data), .rec_has_data_o(rec_hd), .prof_addr_o(prof_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle; outputs sampled 1 ns after the edge that registers it
  task automatic go(input logic v, input logic [1:0] t, input logic c,
                    input logic b, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    valid = v; kind = t; cof = c; bgnd = b; addr = a; data = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    go(1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 16'h0);
  endtask

  task automatic t_reset();
    #3;
    chk("R1 store in reset", store, 0);
    chk("R1 prof in reset", prof_addr, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 store after reset", store, 0);
    chk("R1 rec_addr after reset", rec_addr, 0);
  endtask

  task automatic t_normal();
    mode = 2'd0; win = 1'b1;
    go(1, 0, 1, 0, 16'h1200, 16'hAAAA);
    chk("R2 store", store, 1);
    chk("R2 addr", rec_addr, 16'h1200);
    chk("R2 has_data", rec_hd, 0);
    chk("R2 data zero", rec_data, 0);
    idle();
    chk("R12 single pulse", store, 0);
  endtask

  task automatic t_filter();
    mode = 2'd0;
    go(1, 0, 0, 0, 16'h1300, 0); chk("R3 seq fetch", store, 0);
    go(1, 1, 1, 0, 16'h1304, 0); chk("R3 free", store, 0);
    go(1, 2, 1, 0, 16'h1308, 5); chk("R3 read", store, 0);
    go(1, 3, 0, 0, 16'h130C, 6); chk("R3 write", store, 0);
    chk("R3 rec kept", rec_addr, 16'h1200);
  endtask

  task automatic t_bgnd();
    mode = 2'd0;
    go(1, 0, 1, 1, 16'h1400, 0); chk("R4 bgnd normal", store, 0);
    mode = 2'd1;
    go(1, 0, 1, 1, 16'h1404, 0); chk("R4 bgnd loop", store, 0);
    idle();
  endtask

  task automatic t_loop();
    mode = 2'd1;
    arm = 1'b1; idle(); arm = 1'b0;
    go(1, 0, 1, 0, 16'h2000, 0); chk("R5 first A", store, 1);
    go(1, 0, 1, 0, 16'h2000, 0); chk("R5 dup A", store, 0);
    go(1, 0, 1, 0, 16'h2100, 0); chk("R5 B", store, 1);
    chk("R5 B addr", rec_addr, 16'h2100);
    go(1, 0, 1, 0, 16'h2000, 0); chk("R5 A again", store, 1);
    chk("R5 A addr", rec_addr, 16'h2000);
    idle();
  endtask

  task automatic t_arm();
    mode = 2'd1;
    arm = 1'b1;
    go(1, 0, 1, 0, 16'h2000, 0); arm = 1'b0;
    chk("R6 dup with arm stored", store, 1);
    go(1, 0, 1, 0, 16'h2000, 0); chk("R6 dup after reload", store, 0);
    arm = 1'b1; idle(); arm = 1'b0;
    go(1, 0, 1, 0, 16'h2000, 0); chk("R6 after arm", store, 1);
    idle();
  endtask

  task automatic t_window();
    mode = 2'd1;
    go(1, 0, 1, 0, 16'h3000, 0); chk("R9 setup", store, 1);
    win = 1'b0;
    go(1, 0, 1, 0, 16'h3100, 0); chk("R9 closed loop", store, 0);
    mode = 2'd2;
    go(1, 2, 0, 0, 16'h3200, 7); chk("R9 closed detail", store, 0);
    mode = 2'd1; win = 1'b1;
    go(1, 0, 1, 0, 16'h3000, 0); chk("R9 history unchanged", store, 0);
    idle();
  endtask

  task automatic t_detail();
    mode = 2'd2;
    go(1, 2, 0, 0, 16'h4000, 16'hBEEF);
    chk("R7 read store", store, 1);
    chk("R7 read data", rec_data, 16'hBEEF);
    chk("R7 has_data", rec_hd, 1);
    go(1, 3, 1, 0, 16'h4002, 16'h1234);
    chk("R7 write store", store, 1);
    chk("R7 write addr", rec_addr, 16'h4002);
    go(1, 0, 1, 0, 16'h4004, 0); chk("R7 fetch skipped", store, 0);
    go(1, 1, 0, 0, 16'h4006, 0); chk("R7 free skipped", store, 0);
    idle();
  endtask

  task automatic t_profile();
    mode = 2'd3;
    go(1, 0, 1, 0, 16'h5000, 0); chk("R8 fetch", store, 0);
    go(1, 2, 0, 0, 16'h5002, 1); chk("R8 read", store, 0);
    @(negedge clk); start = 1'b1;
    go(0, 0, 0, 0, 16'h5100, 0);
    chk("R10 sampled", prof_addr, 16'h5100);
    poll = 1'b1;
    go(0, 0, 0, 0, 16'h5200, 0);
    chk("R11 held on start", prof_addr, 16'h5100);
    start = 1'b0;
    go(0, 0, 0, 0, 16'h5300, 0);
    chk("R11 still held", prof_addr, 16'h5100);
    poll = 1'b0; start = 1'b1;
    go(0, 0, 0, 0, 16'h5400, 0);
    chk("R10 resumes", prof_addr, 16'h5400);
    start = 1'b0;
    idle();
  endtask

  task automatic t_strobe();
    mode = 2'd0;
    go(1, 0, 1, 0, 16'h6000, 0);
    chk("R12 first", store, 1); chk("R12 first addr", rec_addr, 16'h6000);
    go(1, 0, 1, 0, 16'h6010, 0);
    chk("R12 second", store, 1); chk("R12 second addr", rec_addr, 16'h6010);
    idle();
    chk("R12 drop", store, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_filter();
    t_bgnd();
    t_loop();
    t_arm();
    t_window();
    t_detail();
    t_profile();
    t_strobe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule